// File: doc/BRIEF.md
# Dual-Channel Storage Register Window Decoder

This block sits between a host programmed-I/O port and a two-channel disk interface controller. Each host access is compared against five address windows: a command window and a control window for each of the two channels, and one bus-master window that both channels share. The base address and length of every window arrive as inputs. For the window that is hit, the block reports the window kind, the channel, and the offset from the window base. Both channels can hold two devices, so the block also reports which of the four devices the access reaches.

Host writes to the drive-select register of a command window are snooped. One bit of the written byte is kept as a per-channel shadow, and this shadow selects which device on that channel receives later command and control accesses. Two enable flags gate the traffic. Both are loaded from the configuration command word. When I/O decoding is off, all accesses are dropped silently. When bus mastering is off, writes to the bus-master window are dropped. An access that hits no window, or that has an illegal width, raises an error strobe. Results appear one clock after the access.

Top module: `ide_win_decode`

## Requirements
- R1: Window priority is fixed at primary command (index 0), primary control (1), secondary command (2), secondary control (3), bus-master (4). The lowest index wins when windows overlap, and a window is hit when base <= address < base + length.
- R2: `out_offset` equals the access address minus the base of the window that was hit.
- R3: `out_type` encodes the window kind: 0 = command, 1 = control, 2 = bus-master, 3 = none. In the bus-master window, an offset below 0x8 reports the primary channel (`out_secondary` = 0), and any other offset reports the secondary channel.
- R4: An accepted write to a command window at offset 6 loads that channel's shadow device bit from bit 4 of `acc_wdata`. Both shadow bits reset to 0. No other access changes them.
- R5: For command and control hits, `out_dev_sel` is one-hot at bit (channel*2 + shadow bit), with primary as channel 0. A write that updates the shadow is routed with the new bit. Bus-master hits drive `out_dev_sel` = 0.
- R6: While I/O decoding is disabled, no access produces `out_valid` or `out_err`, and writes leave the shadow bits unchanged.
- R7: While bus mastering is disabled, bus-master window writes are dropped without error. Bus-master window reads still pass.
- R8: Widths of 1, 2 and 4 bytes are legal, except that a 4-byte access to a command or control window is illegal. An illegal width raises `out_err` and the access is not forwarded.
- R9: A `cfg_wr` pulse loads the I/O enable from bit 0 of `cfg_cmd` and the bus-master enable from bit 2. The new enables apply from the next cycle, and both reset to 0.
- R10: An access that hits no window raises `out_err` with `out_valid` = 0, `out_dev_sel` = 0 and `out_type` = 3.
- R11: Outputs are registered with one cycle of latency. A cycle with no access yields `out_valid` = 0 and `out_err` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration command word write strobe |
| cfg_cmd | input | CW | Configuration command word |
| win_base | input | 5*AW | Window base addresses, window 0 in the low slice |
| win_len | input | 5*AW | Window lengths in bytes, same packing as the bases |
| acc_valid | input | 1 | Host access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Access address |
| acc_bytes | input | 3 | Access width in bytes |
| acc_wdata | input | 8 | Low byte of write data |
| out_valid | output | 1 | Access forwarded |
| out_write | output | 1 | Forwarded access is a write |
| out_type | output | 2 | Window kind code |
| out_secondary | output | 1 | Channel flag, 1 = secondary |
| out_offset | output | AW | Offset within the hit window |
| out_dev_sel | output | 4 | One-hot target device |
| out_err | output | 1 | Decode or width error strobe |

## Verification
The shadow device bits are the only hidden state besides the two enables. A wrong shadow bit shows up as a one-hot select on the wrong device at the very next command or control access to that channel, one cycle after the access is issued. The directed tests therefore follow every shadow-touching write, including illegal-width writes, writes at other offsets, and writes made while decoding is disabled, with a read that exposes the routing. A wrong enable flag shows up on the first gated access after the configuration write, either as a forwarded access or as an error strobe that should not appear.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

    localparam int NUM_WIN    = 5;
    localparam int IDX_W      = 3;
    localparam int NUM_CH     = 2;
    localparam int NUM_DEV    = 4;

    typedef enum logic [1:0] {
        WIN_CMD  = 2'd0,
        WIN_CTL  = 2'd1,
        WIN_BM   = 2'd2,
        WIN_NONE = 2'd3
    } win_kind_e;

    // kind of window for a priority index
    function automatic win_kind_e kind_of(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0, 3'd2: return WIN_CMD;
            3'd1, 3'd3: return WIN_CTL;
            3'd4:       return WIN_BM;
            default:    return WIN_NONE;
        endcase
    endfunction

    // fixed channel of a command or control window
    function automatic logic chan_of(input logic [IDX_W-1:0] idx);
        return (idx == 3'd2) || (idx == 3'd3);
    endfunction

    function automatic logic width_ok(input logic [2:0] bytes, input win_kind_e k);
        return (bytes == 3'd1) || (bytes == 3'd2) || ((bytes == 3'd4) && (k == WIN_BM));
    endfunction

endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    output logic          hit,
    output logic [AW-1:0] off
);
    logic [AW:0] upper;

    always_comb begin
        upper = {1'b0, base} + {1'b0, len};
        hit   = (addr >= base) && ({1'b0, addr} < upper);
        off   = addr - base;
    end
endmodule

// File: rtl/ide_win_select.sv
module ide_win_select
    import ide_win_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [NUM_WIN-1:0]    hit,
    input  logic [NUM_WIN*AW-1:0] offs,
    output logic                  any_hit,
    output logic [IDX_W-1:0]      idx,
    output logic [AW-1:0]         off
);
    always_comb begin
        any_hit = 1'b0;
        idx     = '0;
        off     = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit[w]) begin
                any_hit = 1'b1;
                idx     = IDX_W'(w);
                off     = offs[w*AW +: AW];
            end
        end
    end
endmodule

// File: rtl/ide_dev_shadow.sv
module ide_dev_shadow #(
    parameter int NCH = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd,
    input  logic [$clog2(NCH)-1:0] ch,
    input  logic                   bit_in,
    output logic [NCH-1:0]         shadow
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                shadow[c] <= 1'b0;
            else if (upd && (ch == c))
                shadow[c] <= bit_in;
        end
    end
endmodule

// File: rtl/ide_win_decode.sv
module ide_win_decode
    import ide_win_pkg::*;
#(
    parameter int AW        = 16,
    parameter int CW        = 16,
    parameter int SEL_OFF   = 6,
    parameter int DEV_BIT   = 4,
    parameter int BM_SPLIT  = 8,
    parameter int IO_EN_BIT = 0,
    parameter int BM_EN_BIT = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic [CW-1:0]         cfg_cmd,
    input  logic [NUM_WIN*AW-1:0] win_base,
    input  logic [NUM_WIN*AW-1:0] win_len,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [AW-1:0]         acc_addr,
    input  logic [2:0]            acc_bytes,
    input  logic [7:0]            acc_wdata,
    output logic                  out_valid,
    output logic                  out_write,
    output logic [1:0]            out_type,
    output logic                  out_secondary,
    output logic [AW-1:0]         out_offset,
    output logic [NUM_DEV-1:0]    out_dev_sel,
    output logic                  out_err
);
    typedef struct packed {
        logic              valid;
        logic              write;
        win_kind_e         kind;
        logic              sec;
        logic [AW-1:0]     off;
        logic [NUM_DEV-1:0] dev;
        logic              err;
    } dec_res_t;

    logic                  io_en, bm_en;
    logic [NUM_WIN-1:0]    hits;
    logic [NUM_WIN*AW-1:0] offs;
    logic                  any_hit;
    logic [IDX_W-1:0]      win_idx;
    logic [AW-1:0]         win_off;
    logic [NUM_CH-1:0]     shadow;
    logic                  shadow_upd;
    logic                  route_bit;
    win_kind_e             kind;
    logic                  chan;
    dec_res_t              nxt, cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            io_en <= 1'b0;
            bm_en <= 1'b0;
        end else if (cfg_wr) begin
            io_en <= cfg_cmd[IO_EN_BIT];
            bm_en <= cfg_cmd[BM_EN_BIT];
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        ide_win_match #(.AW(AW)) u_match (
            .addr (acc_addr),
            .base (win_base[w*AW +: AW]),
            .len  (win_len[w*AW +: AW]),
            .hit  (hits[w]),
            .off  (offs[w*AW +: AW])
        );
    end

    ide_win_select #(.AW(AW)) u_sel (
        .hit     (hits),
        .offs    (offs),
        .any_hit (any_hit),
        .idx     (win_idx),
        .off     (win_off)
    );

    ide_dev_shadow #(.NCH(NUM_CH)) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .upd    (shadow_upd),
        .ch     (chan),
        .bit_in (acc_wdata[DEV_BIT]),
        .shadow (shadow)
    );

    always_comb begin
        kind       = any_hit ? kind_of(win_idx) : WIN_NONE;
        chan       = (kind == WIN_BM) ? (win_off >= AW'(BM_SPLIT)) : chan_of(win_idx);
        nxt        = '0;
        nxt.kind   = WIN_NONE;
        shadow_upd = 1'b0;
        route_bit  = shadow[chan];
        if (acc_valid && io_en) begin
            if (!any_hit || !width_ok(acc_bytes, kind)) begin
                nxt.err = 1'b1;
            end else if (!(kind == WIN_BM && acc_write && !bm_en)) begin
                nxt.valid = 1'b1;
                nxt.write = acc_write;
                nxt.kind  = kind;
                nxt.sec   = chan;
                nxt.off   = win_off;
                if (kind != WIN_BM) begin
                    shadow_upd = acc_write && (kind == WIN_CMD) && (win_off == AW'(SEL_OFF));
                    if (shadow_upd)
                        route_bit = acc_wdata[DEV_BIT];
                    nxt.dev[{chan, route_bit}] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            cur.kind <= WIN_NONE;
        end else begin
            cur <= nxt;
        end
    end

    assign out_valid     = cur.valid;
    assign out_write     = cur.write;
    assign out_type      = cur.kind;
    assign out_secondary = cur.sec;
    assign out_offset    = cur.off;
    assign out_dev_sel   = cur.dev;
    assign out_err       = cur.err;
endmodule

// File: rtl/ide_win_decode_chk.sv
module ide_win_decode_chk #(
    parameter int NDEV = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            acc_valid,
    input logic            acc_write,
    input logic            io_en,
    input logic            bm_en,
    input logic            out_valid,
    input logic            out_write,
    input logic [1:0]      out_type,
    input logic [NDEV-1:0] out_dev_sel,
    input logic            out_err
);
    // R5
    dev_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_dev_sel));

    // R5
    bm_nodev_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_type == 2'd2) |-> (out_dev_sel == '0));

    // R6
    io_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(io_en) |-> (!out_valid && !out_err));

    // R7
    bm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_write && out_type == 2'd2) |-> $past(bm_en));

    // R10
    err_shape_chk: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (!out_valid && out_dev_sel == '0 && out_type == 2'd3));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(acc_valid) |-> (!out_valid && !out_err));

    // R11
    write_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_write == $past(acc_write)));
endmodule

bind ide_win_decode ide_win_decode_chk #(.NDEV(4)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .io_en       (io_en),
    .bm_en       (bm_en),
    .out_valid   (out_valid),
    .out_write   (out_write),
    .out_type    (out_type),
    .out_dev_sel (out_dev_sel),
    .out_err     (out_err)
);

// File: tb/ide_win_decode_test.sv
module ide_win_decode_test;
    localparam int AW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_wr = 1'b0;
    logic [15:0]     cfg_cmd = '0;
    logic [5*AW-1:0] win_base;
    logic [5*AW-1:0] win_len;
    logic            acc_valid = 1'b0;
    logic            acc_write = 1'b0;
    logic [AW-1:0]   acc_addr = '0;
    logic [2:0]      acc_bytes = 3'd1;
    logic [7:0]      acc_wdata = '0;
    logic            out_valid, out_write, out_secondary, out_err;
    logic [1:0]      out_type;
    logic [AW-1:0]   out_offset;
    logic [3:0]      out_dev_sel;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    ide_win_decode uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_cmd(cfg_cmd),
        .win_base(win_base), .win_len(win_len),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_bytes(acc_bytes), .acc_wdata(acc_wdata),
        .out_valid(out_valid), .out_write(out_write), .out_type(out_type),
        .out_secondary(out_secondary), .out_offset(out_offset),
        .out_dev_sel(out_dev_sel), .out_err(out_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input logic v, input logic [1:0] t,
                              input logic s, input logic [15:0] off,
                              input logic [3:0] dev, input logic e);
        chk(req, "valid", 32'(out_valid), 32'(v));
        chk(req, "err", 32'(out_err), 32'(e));
        chk(req, "dev_sel", 32'(out_dev_sel), 32'(dev));
        chk(req, "type", 32'(out_type), 32'(t));
        if (v) begin
            chk(req, "secondary", 32'(out_secondary), 32'(s));
            chk(req, "offset", 32'(out_offset), 32'(off));
        end
    endtask

    task automatic access(input logic w, input logic [15:0] a,
                          input logic [2:0] b, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_bytes = b; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic cfg(input logic [15:0] c);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_cmd = c;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_windows(input logic [15:0] scmd);
        win_base[0*AW +: AW] = 16'h01F0; win_len[0*AW +: AW] = 16'd8;
        win_base[1*AW +: AW] = 16'h03F4; win_len[1*AW +: AW] = 16'd4;
        win_base[2*AW +: AW] = scmd;     win_len[2*AW +: AW] = 16'd8;
        win_base[3*AW +: AW] = 16'h0374; win_len[3*AW +: AW] = 16'd4;
        win_base[4*AW +: AW] = 16'hC000; win_len[4*AW +: AW] = 16'd16;
    endtask

    task automatic t_reset();
        expect_out("R11 reset", 0, 2'd3, 0, 0, 4'b0000, 0);
    endtask

    task automatic t_io_off();
        access(0, 16'h01F2, 3'd1, 8'h00);
        expect_out("R6 read while io off", 0, 2'd3, 0, 0, 4'b0000, 0);
        access(1, 16'h01F6, 3'd1, 8'h10);
        expect_out("R6 select write while io off", 0, 2'd3, 0, 0, 4'b0000, 0);
        access(0, 16'h0100, 3'd1, 8'h00);
        expect_out("R6 miss while io off", 0, 2'd3, 0, 0, 4'b0000, 0);
    endtask

    task automatic t_windows();
        access(0, 16'h01F0, 3'd1, 8'h00);
        expect_out("R6 R4 shadow untouched after io-off write", 1, 2'd0, 0, 16'h0, 4'b0001, 0);
        access(0, 16'h01F3, 3'd2, 8'h00);
        expect_out("R1 R2 primary command", 1, 2'd0, 0, 16'h3, 4'b0001, 0);
        access(0, 16'h03F6, 3'd1, 8'h00);
        expect_out("R1 R2 primary control", 1, 2'd1, 0, 16'h2, 4'b0001, 0);
        access(0, 16'h0177, 3'd1, 8'h00);
        expect_out("R1 R5 secondary command top byte", 1, 2'd0, 1, 16'h7, 4'b0100, 0);
        access(0, 16'h0374, 3'd1, 8'h00);
        expect_out("R1 R5 secondary control", 1, 2'd1, 1, 16'h0, 4'b0100, 0);
        access(0, 16'h01F8, 3'd1, 8'h00);
        expect_out("R10 one past primary command", 0, 2'd3, 0, 0, 4'b0000, 1);
        access(0, 16'h01EF, 3'd1, 8'h00);
        expect_out("R10 one below primary command", 0, 2'd3, 0, 0, 4'b0000, 1);
    endtask

    task automatic t_idle();
        @(negedge clk);
        expect_out("R11 idle cycle", 0, 2'd3, 0, 0, 4'b0000, 0);
    endtask

    task automatic t_bm();
        access(1, 16'hC000, 3'd1, 8'h01);
        expect_out("R7 bm write dropped", 0, 2'd3, 0, 0, 4'b0000, 0);
        access(0, 16'hC007, 3'd1, 8'h00);
        expect_out("R7 R3 bm read primary half", 1, 2'd2, 0, 16'h7, 4'b0000, 0);
        access(0, 16'hC008, 3'd1, 8'h00);
        expect_out("R3 bm read secondary half", 1, 2'd2, 1, 16'h8, 4'b0000, 0);
        cfg(16'h0005);
        access(1, 16'hC00A, 3'd4, 8'h00);
        expect_out("R9 R8 bm dword write enabled", 1, 2'd2, 1, 16'hA, 4'b0000, 0);
        chk("R9 write flag", "write", 32'(out_write), 32'd1);
    endtask

    task automatic t_shadow();
        access(1, 16'h01F6, 3'd1, 8'h10);
        expect_out("R4 R5 select write routes new bit", 1, 2'd0, 0, 16'h6, 4'b0010, 0);
        access(0, 16'h01F0, 3'd1, 8'h00);
        expect_out("R4 primary follows shadow", 1, 2'd0, 0, 16'h0, 4'b0010, 0);
        access(0, 16'h0170, 3'd1, 8'h00);
        expect_out("R4 secondary shadow independent", 1, 2'd0, 1, 16'h0, 4'b0100, 0);
        access(1, 16'h0176, 3'd1, 8'hEF);
        expect_out("R4 secondary select bit4 clear", 1, 2'd0, 1, 16'h6, 4'b0100, 0);
        access(1, 16'h0176, 3'd1, 8'h10);
        expect_out("R5 secondary slave", 1, 2'd0, 1, 16'h6, 4'b1000, 0);
        access(0, 16'h0375, 3'd1, 8'h00);
        expect_out("R5 control routed by shadow", 1, 2'd1, 1, 16'h1, 4'b1000, 0);
        access(1, 16'h01F6, 3'd4, 8'h00);
        expect_out("R8 dword to command window", 0, 2'd3, 0, 0, 4'b0000, 1);
        access(1, 16'h01F5, 3'd1, 8'h00);
        expect_out("R4 other offset", 1, 2'd0, 0, 16'h5, 4'b0010, 0);
        access(0, 16'h01F1, 3'd1, 8'h00);
        expect_out("R4 shadow kept after illegal and other writes", 1, 2'd0, 0, 16'h1, 4'b0010, 0);
        access(1, 16'h03F6, 3'd1, 8'h00);
        expect_out("R4 control window write no update", 1, 2'd1, 0, 16'h2, 4'b0010, 0);
        access(1, 16'h01F6, 3'd1, 8'h00);
        expect_out("R4 back to master", 1, 2'd0, 0, 16'h6, 4'b0001, 0);
    endtask

    task automatic t_size();
        access(0, 16'h0172, 3'd4, 8'h00);
        expect_out("R8 dword read command", 0, 2'd3, 0, 0, 4'b0000, 1);
        access(0, 16'h03F4, 3'd3, 8'h00);
        expect_out("R8 width three", 0, 2'd3, 0, 0, 4'b0000, 1);
        access(0, 16'h0374, 3'd2, 8'h00);
        expect_out("R8 word control", 1, 2'd1, 1, 16'h0, 4'b1000, 0);
        access(0, 16'hC004, 3'd4, 8'h00);
        expect_out("R8 dword bm read", 1, 2'd2, 0, 16'h4, 4'b0000, 0);
    endtask

    task automatic t_prio();
        set_windows(16'h01F4);
        access(0, 16'h01F5, 3'd1, 8'h00);
        expect_out("R1 overlap lower index wins", 1, 2'd0, 0, 16'h5, 4'b0001, 0);
        access(0, 16'h01F9, 3'd1, 8'h00);
        expect_out("R1 overlap tail to secondary", 1, 2'd0, 1, 16'h5, 4'b1000, 0);
        set_windows(16'h0170);
    endtask

    task automatic t_disable();
        cfg(16'h0004);
        access(0, 16'hC000, 3'd1, 8'h00);
        expect_out("R9 R6 io cleared", 0, 2'd3, 0, 0, 4'b0000, 0);
        access(0, 16'h0200, 3'd1, 8'h00);
        expect_out("R6 miss silent when io off", 0, 2'd3, 0, 0, 4'b0000, 0);
    endtask

    initial begin
        #400000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        set_windows(16'h0170);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_io_off();
        cfg(16'h0001);
        t_windows();
        t_idle();
        t_bm();
        t_shadow();
        t_size();
        t_prio();
        t_disable();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule